// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps the time of day for a network MAC as an unsigned seconds count and a sub-second count. Both advance on every PTP reference clock edge. Each time they advance, the sub-second field grows by a programmable 8-bit increment, and it rolls into the seconds field at a selectable boundary. In decimal rollover the sub-second field counts nanoseconds and wraps at one billion. In binary rollover it counts units of about 0.465 ns and wraps at 2^31.

Software trims the rate in two ways. In coarse mode the increment is applied on every clock. In fine mode a 32-bit addend is added to a 32-bit phase accumulator on every clock, and the increment is applied only when that accumulator overflows. The register-write port carries three self-clearing commands:
- load the time outright;
- add a signed offset to the running time in a single step;
- copy a new addend into the accumulator path.

To subtract an offset, software writes the modular complement of the offset and sets the subtract flag. The block then adds the two values and absorbs the borrow.

Software reads seconds and sub-seconds separately. If the seconds value differs between two reads taken around a sub-second read, a rollover happened in between and software should read again.

Top module: `ptp_systime`

## Requirements
- R1: After reset, seconds, sub-seconds, the control readback and the active addend are all zero.
- R2: Register writes take effect at the clock edge that samples them. Address 0 is control: bit 0 selects fine mode, bit 1 selects decimal rollover, bit 2 is initialise, bit 3 is time update, bit 4 is addend reload. Address 1 is the 8-bit increment. Address 2 is the addend. Address 3 is the update seconds. Address 4 is the update sub-seconds in bits 30:0, with the subtract flag in bit 31. In coarse mode the sub-second field grows by the increment on every clock.
- R3: In decimal rollover, a sub-second sum at or above 1,000,000,000 is reduced by that amount, and one is carried into seconds.
- R4: In binary rollover, a sub-second sum at or above 2^31 is reduced by 2^31, and one is carried into seconds.
- R5: In fine mode the addend is added to a 32-bit accumulator each clock, and the increment is applied only on clocks where that sum carries out. An addend of 2^31 therefore applies the increment on every second clock.
- R6: A control write with bit 2 set loads seconds and sub-seconds from the update registers at the next edge, with no increment on that edge. The readback bit 2 is 1 for exactly one cycle.
- R7: A control write with bit 4 set copies the addend register into the active addend at the next edge, and readback bit 4 then clears. An active addend of zero in fine mode freezes the time.
- R8: A time update with the subtract flag 0 adds the update seconds and sub-seconds to the time, with no increment on that edge. A sub-second sum past the rollover is reduced and carries one into seconds.
- R9: With the subtract flag 1, the update values are added as well. If the sub-second sum reaches the rollover, it is reduced by it. Otherwise the sum is kept and one is borrowed from seconds, so writing (2^32 minus the offset seconds) and (rollover minus the offset sub-seconds) subtracts the offset.
- R10: Only one command executes per clock. Initialise goes before time update, and time update goes before addend reload. A lower-priority command stays pending until the ones above it have run.
- R11: Seconds wrap from 2^32-1 to 0 on a carry.
- R12: Control readback shows bit 0 fine, bit 1 decimal, and bits 4:2 as the pending commands. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PTP reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| sec_o | output | 32 | Current seconds |
| subsec_o | output | 31 | Current sub-seconds |
| ctrl_o | output | 5 | Mode bits and pending command bits |

## Verification
The assertions assume that update sub-second values and the running sub-second field stay below the rollover of the selected mode. They also assume that the mode is not switched from binary to decimal while the field holds a value above one billion. The stimulus respects both assumptions: it loads in-range values, and it changes mode only right before an initialise or while the field is small. A behavioural model in the bench follows every register write and every command. The bench compares seconds, sub-seconds and the control readback against that model on every clock. Directed cases then pin down the rollovers, borrows, wrap, priority and frozen time.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_INIT   = 2'd1,
    CMD_ADJ    = 2'd2,
    CMD_RELOAD = 2'd3
  } ptp_cmd_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_INC     = 3'd1;
  localparam logic [ADDR_W-1:0] REG_ADDEND  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_UPD_SEC = 3'd3;
  localparam logic [ADDR_W-1:0] REG_UPD_SUB = 3'd4;

  localparam int unsigned CTL_FINE   = 0;
  localparam int unsigned CTL_DEC    = 1;
  localparam int unsigned CTL_INIT   = 2;
  localparam int unsigned CTL_ADJ    = 3;
  localparam int unsigned CTL_RELOAD = 4;
  localparam int unsigned CTL_W      = 5;
  localparam int unsigned NCMD       = 3;
endpackage

// File: rtl/ptp_regs.sv
module ptp_regs
  import ptp_systime_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned SUB_W  = 31,
  parameter int unsigned INC_W  = 8,
  parameter int unsigned ADD_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fine_o,
  output logic              dec_o,
  output logic [NCMD-1:0]   pend_o,
  output ptp_cmd_e          cmd_o,
  output logic [INC_W-1:0]  inc_o,
  output logic [ADD_W-1:0]  addend_o,
  output logic [SEC_W-1:0]  upd_sec_o,
  output logic [SUB_W-1:0]  upd_sub_o,
  output logic              add_sub_o
);
  // pending command vector: [0] init, [1] adjust, [2] reload
  logic              fine_q, dec_q;
  logic [NCMD-1:0]   pend_q, pend_d, exec;
  logic [INC_W-1:0]  inc_q;
  logic [ADD_W-1:0]  addend_q;
  logic [SEC_W-1:0]  usec_q;
  logic [SUB_W-1:0]  usub_q;
  logic              addsub_q;
  logic              ctrl_we, inc_we, add_we, usec_we, usub_we;
  logic [NCMD-1:0]   wr_cmd;
  ptp_cmd_e          cmd;

  always_comb begin
    ctrl_we = wr_en_i && (wr_addr_i == REG_CTRL);
    inc_we  = wr_en_i && (wr_addr_i == REG_INC);
    add_we  = wr_en_i && (wr_addr_i == REG_ADDEND);
    usec_we = wr_en_i && (wr_addr_i == REG_UPD_SEC);
    usub_we = wr_en_i && (wr_addr_i == REG_UPD_SUB);
    wr_cmd  = ctrl_we ? wr_data_i[CTL_RELOAD:CTL_INIT] : '0;
  end

  // fixed priority: init, then adjust, then reload
  always_comb begin
    exec = '0;
    cmd  = CMD_IDLE;
    if (pend_q[0]) begin
      exec[0] = 1'b1;
      cmd     = CMD_INIT;
    end else if (pend_q[1]) begin
      exec[1] = 1'b1;
      cmd     = CMD_ADJ;
    end else if (pend_q[2]) begin
      exec[2] = 1'b1;
      cmd     = CMD_RELOAD;
    end
    pend_d = (pend_q & ~exec) | wr_cmd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q   <= 1'b0;
      dec_q    <= 1'b0;
      pend_q   <= '0;
      inc_q    <= '0;
      addend_q <= '0;
      usec_q   <= '0;
      usub_q   <= '0;
      addsub_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (ctrl_we) begin
        fine_q <= wr_data_i[CTL_FINE];
        dec_q  <= wr_data_i[CTL_DEC];
      end
      if (inc_we)  inc_q    <= wr_data_i[INC_W-1:0];
      if (add_we)  addend_q <= wr_data_i[ADD_W-1:0];
      if (usec_we) usec_q   <= wr_data_i[SEC_W-1:0];
      if (usub_we) begin
        usub_q   <= wr_data_i[SUB_W-1:0];
        addsub_q <= wr_data_i[DATA_W-1];
      end
    end
  end

  assign fine_o    = fine_q;
  assign dec_o     = dec_q;
  assign pend_o    = pend_q;
  assign cmd_o     = cmd;
  assign inc_o     = inc_q;
  assign addend_o  = addend_q;
  assign upd_sec_o = usec_q;
  assign upd_sub_o = usub_q;
  assign add_sub_o = addsub_q;

  AST_INIT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[0] && !wr_cmd[0]) |=> !pend_q[0]); // R6
  AST_RELOAD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == 3'b100 && !wr_cmd[2]) |=> !pend_q[2]); // R7
  AST_ONE_CMD_PER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> ($countones($past(pend_q)) <= $countones(pend_q) + 1)); // R10
  AST_RELOAD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[2] && (pend_q[1:0] != 2'b00)) |=> pend_q[2]); // R10
endmodule

// File: rtl/ptp_accum.sv
module ptp_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fine_i,
  input  logic             reload_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q, add_q;
  logic [ACC_W:0]   sum;
  logic             acc_en;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, add_q};
    acc_en = fine_i;
    tick_o = fine_i ? sum[ACC_W] : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      add_q <= '0;
    end else begin
      if (acc_en)   acc_q <= sum[ACC_W-1:0];
      if (reload_i) add_q <= addend_i;
    end
  end

  AST_ZERO_ADDEND_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && addend_i == '0) |=> (fine_i |-> !tick_o)); // R7
endmodule

// File: rtl/ptp_time.sv
module ptp_time
  import ptp_systime_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned SUB_W   = 31,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned NS_ROLL = 1000000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dec_i,
  input  ptp_cmd_e         cmd_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [SEC_W-1:0] upd_sec_i,
  input  logic [SUB_W-1:0] upd_sub_i,
  input  logic             add_sub_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int unsigned SUM_W = SUB_W + 1;
  localparam logic [SUM_W-1:0] DEC_ROLL = SUM_W'(NS_ROLL);
  localparam logic [SUM_W-1:0] BIN_ROLL = SUM_W'(1) << SUB_W;

  logic [SEC_W-1:0] sec_q, sec_d, sec_step;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SUM_W-1:0] roll, operand, sum, reduced;
  logic             is_init, is_adj, wrap, time_en;

  always_comb begin
    is_init  = (cmd_i == CMD_INIT);
    is_adj   = (cmd_i == CMD_ADJ);
    roll     = dec_i ? DEC_ROLL : BIN_ROLL;
    operand  = is_adj ? {1'b0, upd_sub_i} : SUM_W'(inc_i);
    sum      = {1'b0, sub_q} + operand;
    wrap     = (sum >= roll);
    reduced  = wrap ? (sum - roll) : sum;
    if (is_adj) begin
      if (add_sub_i) sec_step = upd_sec_i + (wrap ? '0 : {SEC_W{1'b1}});
      else           sec_step = upd_sec_i + SEC_W'(wrap);
    end else begin
      sec_step = SEC_W'(wrap);
    end
    time_en = is_init || is_adj || tick_i;
    if (is_init) begin
      sec_d = upd_sec_i;
      sub_d = upd_sub_i;
    end else begin
      sec_d = sec_q + sec_step;
      sub_d = reduced[SUB_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (time_en) begin
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;

  AST_SEC_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_init && !is_adj) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1))); // R11
  AST_DEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && {1'b0, sub_q} < DEC_ROLL && !is_init && !is_adj) |=> ({1'b0, sub_q} < DEC_ROLL)); // R3
  AST_BIN_NO_EARLY_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !is_init && !is_adj && ({1'b0, sub_q} + SUM_W'(inc_i) < BIN_ROLL)) |=> $stable(sec_q)); // R4
  AST_NO_TICK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !is_init && !is_adj) |=> ($stable(sub_q) && $stable(sec_q))); // R5
endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
  import ptp_systime_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned SUB_W   = 31,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned ADD_W   = 32,
  parameter int unsigned NS_ROLL = 1000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  subsec_o,
  output logic [CTL_W-1:0]  ctrl_o
);
  logic             fine, dec, add_sub, tick;
  logic [NCMD-1:0]  pend;
  ptp_cmd_e         cmd;
  logic [INC_W-1:0] inc;
  logic [ADD_W-1:0] addend;
  logic [SEC_W-1:0] upd_sec;
  logic [SUB_W-1:0] upd_sub;

  ptp_regs #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .ADD_W(ADD_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .fine_o(fine), .dec_o(dec), .pend_o(pend), .cmd_o(cmd),
    .inc_o(inc), .addend_o(addend), .upd_sec_o(upd_sec),
    .upd_sub_o(upd_sub), .add_sub_o(add_sub)
  );

  ptp_accum #(.ACC_W(ADD_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fine_i(fine), .reload_i(cmd == CMD_RELOAD),
    .addend_i(addend), .tick_o(tick)
  );

  ptp_time #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .NS_ROLL(NS_ROLL)
  ) u_time (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick), .dec_i(dec), .cmd_i(cmd), .inc_i(inc),
    .upd_sec_i(upd_sec), .upd_sub_i(upd_sub), .add_sub_i(add_sub),
    .sec_o(sec_o), .sub_o(subsec_o)
  );

  assign ctrl_o = {pend, dec, fine};
endmodule

// File: tb/ptp_systime_tb.sv
module ptp_systime_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sec;
  logic [30:0] subsec;
  logic [4:0]  ctrl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_systime u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sec_o(sec), .subsec_o(subsec), .ctrl_o(ctrl)
  );

  // behavioural reference
  longint m_sec, m_sub, m_acc, m_add, m_addreg, m_inc, m_usec, m_usub, roll, s;
  bit     m_fine, m_dec, m_asub, tick;
  bit [2:0] m_pend;
  int     which;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_acc = 0; m_add = 0; m_addreg = 0; m_inc = 0;
      m_usec = 0; m_usub = 0; m_fine = 0; m_dec = 0; m_asub = 0; m_pend = 0;
    end else begin
      which = m_pend[0] ? 0 : m_pend[1] ? 1 : m_pend[2] ? 2 : 3;
      roll = m_dec ? 64'd1000000000 : 64'd2147483648;
      tick = 1;
      if (m_fine) begin
        tick  = (m_acc + m_add) >= 64'd4294967296;
        m_acc = (m_acc + m_add) % 64'd4294967296;
      end
      if (which == 0) begin
        m_sec = m_usec; m_sub = m_usub;
      end else if (which == 1) begin
        s = m_sub + m_usub;
        if (s >= roll) begin
          s = s - roll;
          if (!m_asub) m_sec = m_sec + 1;
        end else if (m_asub) m_sec = m_sec - 1;
        m_sec = (m_sec + m_usec) & 64'hFFFF_FFFF;
        m_sub = s;
      end else if (tick) begin
        s = m_sub + m_inc;
        if (s >= roll) begin s = s - roll; m_sec = (m_sec + 1) & 64'hFFFF_FFFF; end
        m_sub = s;
      end
      if (which == 2) m_add = m_addreg;
      if (which < 3) m_pend[which] = 1'b0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_fine = wr_data[0]; m_dec = wr_data[1]; m_pend = m_pend | wr_data[4:2]; end
          3'd1: m_inc = wr_data[7:0];
          3'd2: m_addreg = wr_data;
          3'd3: m_usec = wr_data;
          3'd4: begin m_usub = wr_data[30:0]; m_asub = wr_data[31]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("MODEL sec", longint'(sec), m_sec);
      chk("MODEL subsec", longint'(subsec), m_sub);
      chk("MODEL ctrl", longint'(ctrl), longint'({m_pend, m_dec, m_fine}));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sec", sec, 0); chk("R1 subsec", subsec, 0); chk("R1 ctrl", ctrl, 0);

    // R2 coarse stepping
    wr(3'd1, 32'd20); wr(3'd0, 32'd2);
    s0 = subsec;
    repeat (10) @(negedge clk);
    chk("R2 coarse step", subsec, s0 + 200);

    // R6 init, R3 decimal wrap
    wr(3'd3, 32'd5); wr(3'd4, 32'd999999990); wr(3'd0, 32'd6);
    chk("R6 pending", ctrl[2], 1);
    @(negedge clk);
    chk("R6 cleared", ctrl[2], 0); chk("R6 sec", sec, 5); chk("R6 sub", subsec, 999999990);
    @(negedge clk);
    chk("R3 sec", sec, 6); chk("R3 sub", subsec, 10);

    // R4 binary wrap
    wr(3'd0, 32'd0); wr(3'd1, 32'd7); wr(3'd3, 32'd9); wr(3'd4, 32'h7FFF_FFFB); wr(3'd0, 32'd4);
    @(negedge clk);
    chk("R4 sec load", sec, 9); chk("R4 sub load", subsec, 32'h7FFF_FFFB);
    @(negedge clk);
    chk("R4 sec", sec, 10); chk("R4 sub", subsec, 2);

    // R11 seconds wrap
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h7FFF_FFFF); wr(3'd1, 32'd1); wr(3'd0, 32'd4);
    @(negedge clk);
    chk("R11 sec max", sec, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 sec wrap", sec, 0); chk("R11 sub", subsec, 0);

    // R8 add with carry (time frozen with increment 0)
    wr(3'd1, 32'd0); wr(3'd3, 32'd10); wr(3'd4, 32'd100); wr(3'd0, 32'd6);
    @(negedge clk);
    chk("R8 base sec", sec, 10); chk("R8 base sub", subsec, 100);
    wr(3'd3, 32'd3); wr(3'd4, 32'd999999950); wr(3'd0, 32'd10);
    @(negedge clk);
    chk("R8 sec", sec, 14); chk("R8 sub", subsec, 50);

    // R9 subtract with and without borrow
    wr(3'd3, 32'hFFFF_FFFE); wr(3'd4, 32'h8000_0000 | 32'd999999800); wr(3'd0, 32'd10);
    @(negedge clk);
    chk("R9 borrow sec", sec, 11); chk("R9 borrow sub", subsec, 999999850);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h8000_0000 | 32'd999999950); wr(3'd0, 32'd10);
    @(negedge clk);
    chk("R9 nob sec", sec, 10); chk("R9 nob sub", subsec, 999999800);

    // R10 priority
    wr(3'd3, 32'd20); wr(3'd4, 32'd0); wr(3'd2, 32'h8000_0000); wr(3'd0, 32'd30);
    chk("R10 all pending", ctrl, 5'b11110);
    @(negedge clk);
    chk("R10 init first", ctrl, 5'b11010); chk("R10 init sec", sec, 20);
    @(negedge clk);
    chk("R10 adj second", ctrl, 5'b10010); chk("R10 adj sec", sec, 40);
    @(negedge clk);
    chk("R10 reload last", ctrl, 5'b00010);

    // R5 fine mode with addend 2^31
    wr(3'd1, 32'd10); wr(3'd0, 32'd3);
    s0 = subsec;
    repeat (100) @(negedge clk);
    chk("R5 half rate", subsec, s0 + 500);

    // R7 reload zero addend freezes time
    wr(3'd2, 32'd0); wr(3'd0, 32'd19);
    chk("R7 pending", ctrl, 5'b10011);
    @(negedge clk);
    chk("R7 cleared", ctrl, 5'b00011);
    s0 = subsec;
    repeat (20) @(negedge clk);
    chk("R7 frozen", subsec, s0);

    // R12 unused addresses
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R12 ctrl", ctrl, 5'b00011); chk("R12 sub", subsec, s0); chk("R12 sec", sec, 40);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule